// File: doc/BRIEF.md
# Paged Program Window Address Translator

This block keeps a small page-select register and turns 16-bit local CPU addresses into 18-bit global addresses. A local address inside the program window, 0x8000 through 0xBFFF, goes to one of sixteen 16KB pages in a 256KB global space. The register value picks the page. Any local address outside the window maps to a fixed region at the top of the global space, and a flag shows whether the access hit the window.

The register can be read and written at any time through a simple peripheral port, which has an address, a write strobe, write data and combinational read data. A second, privileged load port lets call/return-style operations switch pages. A write from that port is visible on the next cycle, the same as a bus write. When both ports write in the same cycle, the privileged port wins.

Top module: `page_window_xlate`

## Requirements
- R1: After reset the page register holds 0x0E (index 4'b1110), so readback at register address 0x0015 returns 8'h0E.
- R2: A bus write (`reg_we`=1) to address 0x0015 stores `reg_wdata[3:0]` as the index. Readback shows the new value from the next cycle. Bits [7:4] of the write data are discarded and always read back as zero.
- R3: A bus write to any register address other than 0x0015 leaves the index unchanged.
- R4: Reading address 0x0015 returns {4'b0000, index} combinationally. Reading any other address returns 8'h00.
- R5: For a local address in 0x8000–0xBFFF, `glob_addr[17:14]` equals the index, `glob_addr[13:0]` equals `loc_addr[13:0]`, and `in_window` is 1.
- R6: For a local address outside 0x8000–0xBFFF, `glob_addr` equals {2'b11, loc_addr} and `in_window` is 0.
- R7: When `priv_load`=1, the index takes `priv_index`, and translation uses the new value on the next cycle.
- R8: When the bus port and the privileged port both write in the same cycle, the privileged value is stored.
- R9: Translation is combinational from the current index. An index change applies to the access presented in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Register address for the bus port |
| reg_we | input | 1 | Bus write strobe |
| reg_wdata | input | 8 | Bus write data |
| reg_rdata | output | 8 | Combinational bus read data |
| priv_load | input | 1 | Privileged index load strobe |
| priv_index | input | 4 | Privileged index value |
| loc_addr | input | 16 | Local CPU address |
| glob_addr | output | 18 | Translated global address |
| in_window | output | 1 | High when `loc_addr` is inside the paged window |

## Verification
The bench builds the block with its default parameters: a 4-bit index, a 14-bit page offset, a window base of 0x8000 and a register address of 0x0015. With these defaults the bench can reach the edges of the window: 0x7FFF, 0x8000, 0xBFFF and 0xC000. It can also reach every one of the sixteen page values and the collision between the two write paths. Page 0 and page 15 check the extremes of the upper global bits.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
    localparam int IDX_W   = 4;
    localparam int OFF_W   = 14;
    localparam int LOC_W   = 16;
    localparam int GLB_W   = IDX_W + OFF_W;
    localparam int DATA_W  = 8;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } page_state_t;
endpackage

// File: rtl/pwx_page_reg.sv
module pwx_page_reg
    import pwx_pkg::*;
#(
    parameter logic [LOC_W-1:0]  REG_ADDR  = 16'h0015,
    parameter logic [IDX_W-1:0]  RST_INDEX = 4'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              priv_load,
    input  logic [IDX_W-1:0]  priv_index,
    output logic [IDX_W-1:0]  index,
    output logic [DATA_W-1:0] reg_rdata
);
    page_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        hit  = (reg_addr == REG_ADDR);
        st_d = st_q;
        if (priv_load)
            st_d.idx = priv_index;
        else if (reg_we && hit)
            st_d.idx = reg_wdata[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{idx: RST_INDEX};
        else        st_q <= st_d;
    end

    assign index     = st_q.idx;
    assign reg_rdata = hit ? {{(DATA_W-IDX_W){1'b0}}, st_q.idx} : '0;

    p_priv_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        priv_load |=> index == $past(priv_index));
    p_miss_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_load && !(reg_we && reg_addr == REG_ADDR)) |=> $stable(index));
    p_rd_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:IDX_W] == '0);
endmodule

// File: rtl/pwx_xlate.sv
module pwx_xlate
    import pwx_pkg::*;
#(
    parameter logic [1:0] WIN_SEL = 2'b10,
    parameter logic [1:0] FIX_TOP = 2'b11
) (
    input  logic [IDX_W-1:0] index,
    input  logic [LOC_W-1:0] loc_addr,
    output logic [GLB_W-1:0] glob_addr,
    output logic             in_window
);
    localparam int SEL_HI = LOC_W - 1;
    localparam int SEL_LO = OFF_W;

    always_comb begin
        in_window = (loc_addr[SEL_HI:SEL_LO] == WIN_SEL);
        if (in_window)
            glob_addr = {index, loc_addr[OFF_W-1:0]};
        else
            glob_addr = {FIX_TOP, loc_addr};
    end

    always_comb begin
        if (in_window)
            a_win_r5: assert (glob_addr[OFF_W-1:0] == loc_addr[OFF_W-1:0]);
        else
            a_fix_r6: assert (glob_addr[LOC_W-1:0] == loc_addr);
    end
endmodule

// File: rtl/page_window_xlate.sv
module page_window_xlate
    import pwx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] reg_addr,
    input  logic        reg_we,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        priv_load,
    input  logic [3:0]  priv_index,
    input  logic [15:0] loc_addr,
    output logic [17:0] glob_addr,
    output logic        in_window
);
    logic [IDX_W-1:0] index;

    pwx_page_reg u_reg (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .priv_load(priv_load), .priv_index(priv_index),
        .index(index), .reg_rdata(reg_rdata)
    );

    pwx_xlate u_xl (
        .index(index), .loc_addr(loc_addr),
        .glob_addr(glob_addr), .in_window(in_window)
    );

    p_win_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_window |-> glob_addr[17:14] == index);
    p_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_window == (loc_addr >= 16'h8000 && loc_addr <= 16'hBFFF));
endmodule

// File: tb/test_page_window_xlate.sv
module test_page_window_xlate;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] reg_addr = 0;
    logic        reg_we = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic        priv_load = 0;
    logic [3:0]  priv_index = 0;
    logic [15:0] loc_addr = 0;
    logic [17:0] glob_addr;
    logic        in_window;

    int n_chk = 0, n_fail = 0;

    page_window_xlate i_page_window_xlate (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        reg_addr = a; reg_we = 1; reg_wdata = d; step(); reg_we = 0;
    endtask

    function automatic logic [17:0] model(input logic [3:0] idx, input logic [15:0] la);
        if (la >= 16'h8000 && la <= 16'hBFFF) return {idx, la[13:0]};
        return {2'b11, la};
    endfunction

    task automatic t_reset();
        reg_addr = 16'h0015; #1;
        chk("R1 reset readback", reg_rdata, 8'h0E);
        loc_addr = 16'h8123; #1;
        chk("R1 reset page", glob_addr, model(4'hE, 16'h8123));
    endtask

    task automatic t_bus_write();
        bus_wr(16'h0015, 8'hF5); reg_addr = 16'h0015; #1;
        chk("R2 upper bits dropped", reg_rdata, 8'h05);
        bus_wr(16'h0016, 8'h0A); reg_addr = 16'h0015; #1;
        chk("R3 miss write ignored", reg_rdata, 8'h05);
        reg_addr = 16'h0014; #1;
        chk("R4 other address reads zero", reg_rdata, 8'h00);
    endtask

    task automatic t_window();
        logic [15:0] pts [6] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};
        foreach (pts[i]) begin
            loc_addr = pts[i]; #1;
            chk("R5/R6 glob", glob_addr, model(4'h5, pts[i]));
            chk("R5/R6 flag", in_window, (pts[i] >= 16'h8000 && pts[i] <= 16'hBFFF));
        end
    endtask

    task automatic t_all_pages();
        for (int p = 0; p < 16; p++) begin
            bus_wr(16'h0015, 8'(p));
            loc_addr = 16'hA5A5; #1;
            chk("R5 page sweep", glob_addr, model(4'(p), 16'hA5A5));
        end
    endtask

    task automatic t_priv();
        loc_addr = 16'h9000;
        priv_load = 1; priv_index = 4'h3; #1;
        chk("R9 before edge old page", glob_addr, model(4'hF, 16'h9000));
        step(); priv_load = 0; #1;
        chk("R7 priv load applied", glob_addr, model(4'h3, 16'h9000));
        reg_addr = 16'h0015; reg_we = 1; reg_wdata = 8'h0C;
        priv_load = 1; priv_index = 4'h9; step();
        reg_we = 0; priv_load = 0; #1;
        chk("R8 priv wins", reg_rdata, 8'h09);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_bus_write();
        t_window();
        t_all_pages();
        t_priv();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule